// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers event lines from ten banks of thirty-two sources each and folds them into one interrupt line. There are four engine banks, three display pipe banks, a port bank, a miscellaneous bank and a power-unit bank. Each bank has four 32-bit registers:

- a status view of the raw inputs;
- a mask;
- an enable;
- an identity register, which records qualified occurrences.

The identity register is cleared by writing ones to it. Each identity bit has a second slot behind it, so two occurrences of the same event can wait for service.

A master word sits above the banks. Each of its summary bits reports that one bank, or one half of an engine bank, has something recorded. Bit 23 reflects a pending line from an external south-bridge aggregator. Bit 31 is a global enable that software writes. While software services the banks it clears bit 31, which keeps the output low; it sets bit 31 again when done.

Register access uses a simple synchronous port. A write takes effect at the clock edge where it is presented. Read data appears registered one cycle after the read is presented.

In the pipe banks, bit 0 is vertical blank, bit 1 vsync, bit 2 scan-line event and bit 4 flip done. The error events sit at bits 8, 9, 10, 29 and 31. The block treats all of these bits alike.

Top module: `irq_hub`

## Requirements
- R1: After reset every mask register reads all ones, every enable register reads 0, every identity register reads 0 with nothing queued, the master word reads 0 and `irq_o` is low.
- R2: The status register of a bank (offset +0x0) reads the bank's raw event inputs, whatever the mask and enable hold.
- R3: An occurrence is a 0-to-1 transition of an event input. It is recorded in the identity register only if that bit's enable is 1 and its mask is 0. A line held high records a single occurrence.
- R4: Writing a 1 to an identity bit (offset +0x8) clears it. Writing a 0 leaves it unchanged.
- R5: Each identity bit holds up to two occurrences. After the first write-one clear, a queued second occurrence reads back as 1. A third occurrence while two are held is dropped. If a clear and a new occurrence arrive in the same cycle, the clear is applied first.
- R6: Master summary bit positions: 16, 17 and 18 are pipe banks 0, 1 and 2; 20 is the port bank; 22 is the miscellaneous bank; 30 is the power-unit bank. Each is the OR of that bank's identity bits.
- R7: Engine bank 0 reports bits 15:0 on master bit 0 and bits 31:16 on master bit 1. Engine bank 1 reports bits 15:0 on bit 2 and bits 31:16 on bit 3. Engine bank 3 reports on bit 6. Engine bank 2 has no summary bit.
- R8: Only master bit 31, the global enable, is writable. The summary bits ignore writes, and master bits with no source read 0.
- R9: `irq_o` is registered. It is high one cycle after the global enable is set while any summary bit is set, and otherwise low.
- R10: The master word is at byte address 0x00. Bank b (0..9, in the order engine 0-3, pipe 0-2, port, misc, power) is at 0x10*(b+1): status +0x0, mask +0x4, identity +0x8, enable +0xC. An address with nonzero bits 1:0, or outside this map, reads 0 and writes nothing.
- R11: Master bit 23 follows the `sb_pending_i` input and takes part in raising `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NBANK*DW | Event lines, bank b in bits [b*DW +: DW] |
| sb_pending_i | input | 1 | Pending line from the downstream aggregator |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Aggregated interrupt |

## Verification
On every cycle, the assertions check these identity-register rules in each bank:
- nothing enters the identity register without a qualified rising edge;
- a zero in a write leaves a set bit alone;
- a queued occurrence always reappears when its bit is cleared;
- a queued slot never exists without its visible bit.

The master level checks two rules over time: the output falls whenever the global enable is clear, and it rises after a set summary bit. The read path checks that unmapped addresses read 0.

Only the bench scenarios can show the rest:
- the exact summary bit position chosen for each bank and engine half;
- that a held level is counted once;
- the full two-clear drain;
- that the summary bits are read-only through the register port.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
  // bank ordering inside the event vector and address map
  localparam int NENG     = 4;
  localparam int NPIPE    = 3;
  localparam int BK_ENG0  = 0;
  localparam int BK_PIPE0 = NENG;
  localparam int BK_PORT  = NENG + NPIPE;
  localparam int BK_MISC  = BK_PORT + 1;
  localparam int BK_PWR   = BK_MISC + 1;
  localparam int NBANK    = BK_PWR + 1;

  // master word bit positions
  localparam int SUM_E0_LO = 0;
  localparam int SUM_E0_HI = 1;
  localparam int SUM_E1_LO = 2;
  localparam int SUM_E1_HI = 3;
  localparam int SUM_E3    = 6;
  localparam int SUM_PIPE0 = 16;
  localparam int SUM_PORT  = 20;
  localparam int SUM_MISC  = 22;
  localparam int SUM_SB    = 23;
  localparam int SUM_PWR   = 30;

  typedef enum logic [1:0] {
    REG_STAT  = 2'd0,
    REG_MASK  = 2'd1,
    REG_IDENT = 2'd2,
    REG_ENAB  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_hub_bank.sv
`timescale 1ns/1ps
module irq_hub_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] ev_i,
  input  logic          mask_we_i,
  input  logic          enab_we_i,
  input  logic          ident_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] enab_o,
  output logic [DW-1:0] ident_o
);
  logic [DW-1:0] prev_q, mask_q, enab_q, ident_q, queue_q;
  logic [DW-1:0] rise, occ, clr, id_mid, q_mid, id_d, q_d;

  assign rise = ev_i & ~prev_q;
  assign occ  = rise & enab_q & ~mask_q;
  assign clr  = ident_we_i ? wdata_i : '0;

  // clear first (queued slot moves forward), then add the new occurrence
  always_comb begin
    id_mid = (ident_q & ~clr) | (queue_q & clr);
    q_mid  = queue_q & ~clr;
    id_d   = id_mid | occ;
    q_d    = q_mid | (occ & id_mid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      mask_q  <= '1;
      enab_q  <= '0;
      ident_q <= '0;
      queue_q <= '0;
    end else begin
      prev_q  <= ev_i;
      ident_q <= id_d;
      queue_q <= q_d;
      if (mask_we_i) mask_q <= wdata_i;
      if (enab_we_i) enab_q <= wdata_i;
    end
  end

  assign stat_o  = ev_i;
  assign mask_o  = mask_q;
  assign enab_o  = enab_q;
  assign ident_o = ident_q;

  // R3: a newly set identity bit needs a qualified rising edge in the prior cycle
  p_latch_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ident_q & ~$past(ident_q) & ~$past(rise & enab_q & ~mask_q)) == '0));

  // R4: bits not written with one stay set
  p_zero_write_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(ident_q) & ~$past(clr) & ~ident_q) == '0));

  // R5: a queued occurrence reappears after a clear
  p_queue_reappears_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(queue_q) & $past(clr) & ~ident_q) == '0));

  // R5: the second slot is never held without the first
  always_ff @(posedge clk) begin
    if (!rst) begin
      p_queue_behind_ident_r5: assert ((queue_q & ~ident_q) == '0);
    end
  end
endmodule

// File: rtl/irq_hub_master.sv
`timescale 1ns/1ps
module irq_hub_master
  import irq_hub_pkg::*;
#(
  parameter int DW = 32,
  parameter int NP = NPIPE
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   gen_we_i,
  input  logic                   gen_wdata_i,
  input  logic [DW-1:0]          eng0_i,
  input  logic [DW-1:0]          eng1_i,
  input  logic [DW-1:0]          eng3_i,
  input  logic [NP-1:0][DW-1:0]  pipe_i,
  input  logic [DW-1:0]          port_i,
  input  logic [DW-1:0]          misc_i,
  input  logic [DW-1:0]          pwr_i,
  input  logic                   sb_i,
  output logic [DW-1:0]          master_o,
  output logic                   irq_o
);
  localparam int HW = DW / 2;

  logic [DW-2:0] sum;
  logic          gen_q, irq_q;

  always_comb begin
    sum            = '0;
    sum[SUM_E0_LO] = |eng0_i[HW-1:0];
    sum[SUM_E0_HI] = |eng0_i[DW-1:HW];
    sum[SUM_E1_LO] = |eng1_i[HW-1:0];
    sum[SUM_E1_HI] = |eng1_i[DW-1:HW];
    sum[SUM_E3]    = |eng3_i;
    for (int p = 0; p < NP; p++) begin
      sum[SUM_PIPE0 + p] = |pipe_i[p];
    end
    sum[SUM_PORT]  = |port_i;
    sum[SUM_MISC]  = |misc_i;
    sum[SUM_SB]    = sb_i;
    sum[SUM_PWR]   = |pwr_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (gen_we_i) gen_q <= gen_wdata_i;
      irq_q <= gen_q & (|sum);
    end
  end

  assign master_o = {gen_q, sum};
  assign irq_o    = irq_q;

  // R9: global enable clear forces the output low next cycle
  p_gen_gates_r9: assert property (@(posedge clk) disable iff (rst)
    !gen_q |=> !irq_o);

  // R9: enabled and pending raises the output next cycle
  p_pending_raises_r9: assert property (@(posedge clk) disable iff (rst)
    (gen_q && (|master_o[DW-2:0])) |=> irq_o);

  // R8: the global enable only changes through a write
  p_gen_write_only_r8: assert property (@(posedge clk) disable iff (rst)
    !gen_we_i |=> $stable(gen_q));
endmodule

// File: rtl/irq_hub_regs.sv
`timescale 1ns/1ps
module irq_hub_regs
  import irq_hub_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NB = NBANK
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         master_i,
  input  logic [NB-1:0][DW-1:0] stat_i,
  input  logic [NB-1:0][DW-1:0] mask_i,
  input  logic [NB-1:0][DW-1:0] enab_i,
  input  logic [NB-1:0][DW-1:0] ident_i,
  output logic                  gen_we_o,
  output logic [NB-1:0]         mask_we_o,
  output logic [NB-1:0]         enab_we_o,
  output logic [NB-1:0]         ident_we_o,
  output logic [DW-1:0]         rdata_o
);
  localparam int SW = AW - 4;

  logic [SW-1:0] slot;
  reg_sel_e      sel;
  logic          aligned, master_hit, any_hit;
  logic [NB-1:0] bsel;
  logic [DW-1:0] rmux, rdata_q;

  assign slot    = addr_i[AW-1:4];
  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    master_hit = aligned && (slot == '0) && (sel == REG_STAT);
    bsel       = '0;
    rmux       = '0;
    if (master_hit) rmux = master_i;
    for (int b = 0; b < NB; b++) begin
      bsel[b] = aligned && (slot == SW'(b + 1));
      if (bsel[b]) begin
        case (sel)
          REG_STAT:  rmux = stat_i[b];
          REG_MASK:  rmux = mask_i[b];
          REG_IDENT: rmux = ident_i[b];
          default:   rmux = enab_i[b];
        endcase
      end
    end
    any_hit = master_hit || (|bsel);
  end

  assign gen_we_o = wr_en_i && master_hit;

  for (genvar g = 0; g < NB; g++) begin : g_strobe
    assign mask_we_o[g]  = wr_en_i && bsel[g] && (sel == REG_MASK);
    assign enab_we_o[g]  = wr_en_i && bsel[g] && (sel == REG_ENAB);
    assign ident_we_o[g] = wr_en_i && bsel[g] && (sel == REG_IDENT);
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;

  // R10: a read outside the map returns zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !any_hit) |=> (rdata_o == '0));

  // R10: at most one write target per access
  p_single_target_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gen_we_o, mask_we_o, enab_we_o, ident_we_o}));
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NBANK*DW-1:0] ev_i,
  input  logic                sb_pending_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic                irq_o
);
  logic [NBANK-1:0][DW-1:0] stat_w, mask_w, enab_w, ident_w;
  logic [NBANK-1:0]         mask_we, enab_we, ident_we;
  logic [NPIPE-1:0][DW-1:0] pipe_w;
  logic [DW-1:0]            master_w;
  logic                     gen_we;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_hub_bank #(.DW(DW)) i_bank (
      .clk        (clk),
      .rst        (rst),
      .ev_i       (ev_i[b*DW +: DW]),
      .mask_we_i  (mask_we[b]),
      .enab_we_i  (enab_we[b]),
      .ident_we_i (ident_we[b]),
      .wdata_i    (wdata_i),
      .stat_o     (stat_w[b]),
      .mask_o     (mask_w[b]),
      .enab_o     (enab_w[b]),
      .ident_o    (ident_w[b])
    );
  end

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    assign pipe_w[p] = ident_w[BK_PIPE0 + p];
  end

  irq_hub_master #(.DW(DW), .NP(NPIPE)) i_master (
    .clk         (clk),
    .rst         (rst),
    .gen_we_i    (gen_we),
    .gen_wdata_i (wdata_i[DW-1]),
    .eng0_i      (ident_w[BK_ENG0]),
    .eng1_i      (ident_w[BK_ENG0 + 1]),
    .eng3_i      (ident_w[BK_ENG0 + 3]),
    .pipe_i      (pipe_w),
    .port_i      (ident_w[BK_PORT]),
    .misc_i      (ident_w[BK_MISC]),
    .pwr_i       (ident_w[BK_PWR]),
    .sb_i        (sb_pending_i),
    .master_o    (master_w),
    .irq_o       (irq_o)
  );

  irq_hub_regs #(.AW(AW), .DW(DW), .NB(NBANK)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .master_i   (master_w),
    .stat_i     (stat_w),
    .mask_i     (mask_w),
    .enab_i     (enab_w),
    .ident_i    (ident_w),
    .gen_we_o   (gen_we),
    .mask_we_o  (mask_we),
    .enab_we_o  (enab_we),
    .ident_we_o (ident_we),
    .rdata_o    (rdata_o)
  );
endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NB = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic [NB*DW-1:0] ev;
  logic             sb;
  logic             wr_en, rd_en;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata;
  logic [DW-1:0]    rdata;
  logic             irq;

  int vecs = 0;
  int miss = 0;
  logic rd_seen = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic [DW-1:0] e_cur;
  string         t_cur;

  always #5 clk = ~clk;

  irq_hub #(.AW(AW), .DW(DW)) i_irq_hub (
    .clk(clk), .rst(rst), .ev_i(ev), .sb_pending_i(sb),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // bank b register r: 0 status, 1 mask, 2 identity, 3 enable (R10)
  function automatic logic [AW-1:0] ba(int b, int r);
    return AW'((b + 1) * 16 + r * 4);
  endfunction

  // master summary position from R6, R7; -1 when none
  function automatic int sum_pos(int b, int bt);
    case (b)
      0: return (bt < 16) ? 0 : 1;
      1: return (bt < 16) ? 2 : 3;
      3: return 6;
      4, 5, 6: return 16 + b - 4;
      7: return 20;
      8: return 22;
      9: return 30;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) rd_seen <= rd_en;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_seen) begin
      vecs++;
      if (exp_q.size() == 0) begin
        miss++;
        $display("FAIL scoreboard: read with no expectation got %h exp none", rdata);
      end else begin
        e_cur = exp_q.pop_front();
        t_cur = tag_q.pop_front();
        if (rdata !== e_cur) begin
          miss++;
          $display("FAIL %s: got %h exp %h", t_cur, rdata, e_cur);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int b, input int bt);
    @(negedge clk); ev[b*DW + bt] = 1'b1;
    @(negedge clk); ev[b*DW + bt] = 1'b0;
  endtask

  task automatic check_irq(input logic exp, input string tag);
    repeat (2) @(negedge clk);
    vecs++;
    if (irq !== exp) begin
      miss++;
      $display("FAIL %s: irq got %b exp %b", tag, irq, exp);
    end
  endtask

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ev = '0; sb = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_irq(1'b0, "R1 irq after reset");
    rd(8'h00, 32'h0, "R1 master reset");
    rd(ba(0, 1), 32'hFFFF_FFFF, "R1 mask reset bank0");
    rd(ba(9, 1), 32'hFFFF_FFFF, "R1 mask reset bank9");
    rd(ba(4, 3), 32'h0, "R1 enable reset");
    rd(ba(4, 2), 32'h0, "R1 identity reset");

    // R2 raw status, R3 masked edge not recorded
    @(negedge clk); ev[4*DW + 0] = 1'b1;
    rd(ba(4, 0), 32'h1, "R2 status shows raw input");
    @(negedge clk); ev = '0;
    rd(ba(4, 2), 32'h0, "R3 masked and disabled not recorded");

    // R3 enabled but still masked
    wr(ba(4, 3), 32'h1);
    pulse(4, 0);
    rd(ba(4, 2), 32'h0, "R3 enabled but masked not recorded");

    // R3 unmasked: recorded; R6 pipe 0 summary; R9 gate
    wr(ba(4, 1), ~32'h1);
    pulse(4, 0);
    rd(ba(4, 2), 32'h1, "R3 qualified edge recorded");
    rd(8'h00, 32'h0001_0000, "R6 pipe bank 0 summary");
    check_irq(1'b0, "R9 global enable clear holds irq low");

    // R8 only bit 31 writable
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h8001_0000, "R8 summary bits read-only");
    check_irq(1'b1, "R9 irq raised");

    // R4 write-one clear
    wr(ba(4, 2), 32'h0);
    rd(ba(4, 2), 32'h1, "R4 zero write no effect");
    wr(ba(4, 2), 32'h1);
    rd(ba(4, 2), 32'h0, "R4 one write clears");
    check_irq(1'b0, "R9 irq drops after clear");

    // R5 two-deep queue, third dropped
    pulse(4, 0); pulse(4, 0); pulse(4, 0);
    rd(ba(4, 2), 32'h1, "R5 first occurrence visible");
    wr(ba(4, 2), 32'h1);
    rd(ba(4, 2), 32'h1, "R5 second occurrence after first clear");
    wr(ba(4, 2), 32'h1);
    rd(ba(4, 2), 32'h0, "R5 third occurrence dropped");

    // R3 level held counts once
    @(negedge clk); ev[4*DW + 0] = 1'b1;
    repeat (5) @(negedge clk);
    wr(ba(4, 2), 32'h1);
    rd(ba(4, 2), 32'h0, "R3 held level recorded once");
    @(negedge clk); ev = '0;

    // R6 R7 each bank and engine half
    for (int b = 0; b < NB; b++) begin
      wr(ba(b, 3), 32'hFFFF_FFFF);
      wr(ba(b, 1), 32'h0);
      for (int k = 0; k < 2; k++) begin
        int bt;
        int sp;
        if (k == 1 && b > 1) break;
        bt = (k == 0) ? 5 : 21;
        sp = sum_pos(b, bt);
        pulse(b, bt);
        rd(8'h00, 32'h8000_0000 | ((sp >= 0) ? (32'h1 << sp) : 32'h0),
           $sformatf("R6 R7 summary bank %0d bit %0d", b, bt));
        check_irq(sp >= 0, $sformatf("R7 irq bank %0d bit %0d", b, bt));
        wr(ba(b, 2), 32'hFFFF_FFFF);
        rd(ba(b, 2), 32'h0, $sformatf("R4 bank %0d cleared", b));
      end
    end

    // R11 downstream pending line
    @(negedge clk); sb = 1'b1;
    rd(8'h00, 32'h8080_0000, "R11 bit 23 follows pending line");
    check_irq(1'b1, "R11 irq from pending line");
    wr(8'h00, 32'h0);
    check_irq(1'b0, "R9 cleared global enable gates irq");
    rd(8'h00, 32'h0080_0000, "R8 global enable cleared by write");
    @(negedge clk); sb = 1'b0;

    // R10 address map
    wr(ba(9, 1), 32'h1234_5678);
    rd(ba(9, 1), 32'h1234_5678, "R10 bank 9 mask offset");
    rd(ba(9, 1) + 8'h1, 32'h0, "R10 misaligned reads zero");
    rd(8'h04, 32'h0, "R10 unmapped master slot");
    rd(8'hF0, 32'h0, "R10 beyond last bank");
    wr(8'hF4, 32'h0);
    rd(ba(8, 1), 32'hFFFF_FFFF - 32'hFFFF_FFFF, "R10 bank 8 mask unaffected by stray write");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      miss++;
      $display("FAIL scoreboard: got %0d pending exp 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule